// File: doc/BRIEF.md
# Protected Far-Call Descriptor Checker

This block decides what a protected-mode far call turns into once the target selector and its descriptor are known. It takes the selector the call names, the access-rights summary of the descriptor that selector points at, and the current privilege level. It then reports one of five legal transfer kinds or a fault. A fault carries its class and the selector value to push as the error code. When the first descriptor is a call gate or a task gate, the caller also presents the selector held inside the gate and a summary of the descriptor that this inner selector points at. Fetching descriptors and carrying out the transfer are left to the surrounding logic.

The decision is combinational. It is captured in a register on any cycle with `req_valid` high and appears on the outputs one clock later, marked by a one-cycle `res_valid` pulse. The checks form a single priority chain, and the first check that fails decides the result.

Top module: `farcall_gatekeeper`

## Requirements
- R1: A target selector whose bits 15:2 are all zero (index 0 in the global table) yields kind 5 (fault), class 0 (GP) and error code 0, whatever the descriptor says.
- R2: If the target index (bits 15:3) is greater than the limit of its table, the result is GP with the target selector as error code, its two low bits cleared. Bit 2 of the selector picks the table: 1 uses `ldt_lim`, 0 uses `gdt_lim`.
- R3: Descriptor type 1 (conforming code): DPL above CPL gives GP(target); otherwise a clear present bit gives NP (class 1) with error code target; otherwise the result is kind 0.
- R4: Type 2 (nonconforming code): the checks run in this order. RPL above CPL gives GP(target). DPL not equal to CPL gives GP(target). A clear present bit gives NP(target). Otherwise the result is kind 1.
- R5: Type 3 (call gate): a gate DPL below CPL or below RPL gives GP(target); otherwise a gate that is not present gives NP(target).
- R6: For a call gate that passes R5, the inner selector is checked in this order. A null inner selector gives GP(0). An inner index beyond its table limit gives GP(inner). An inner type other than 1 or 2 gives GP(inner). An inner DPL above CPL gives GP(inner). Otherwise the result is kind 3 (more privilege) when the inner type is 2 and the inner DPL is below CPL, and kind 2 (same privilege) in every other case.
- R7: Type 4 (task gate): a gate DPL below CPL or RPL gives TS (class 3) with error code target; otherwise a gate that is not present gives NP(target). After that, the following give TS(inner): an inner selector with bit 2 set, an inner index above `gdt_lim`, or an inner type other than 5 or with the busy bit set. An inner TSS that is not present gives NP(inner). Otherwise the result is kind 4.
- R8: Type 5 (TSS): a DPL below CPL or RPL gives TS(target); otherwise a set busy bit gives TS(target); otherwise a clear present bit gives NP(target); otherwise the result is kind 4.
- R9: Types 0, 6 and 7 give GP(target).
- R10: Reset clears every output to zero. `res_valid` is high exactly in the cycle after a cycle with `req_valid` high. The result outputs hold their value while no request arrives. A non-fault result has class 0 and error code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Evaluate the inputs this cycle |
| tgt_sel | input | SEL_W | Selector named by the call: index, table bit, RPL |
| gdt_lim | input | SEL_W-3 | Highest valid index in the global table |
| ldt_lim | input | SEL_W-3 | Highest valid index in the local table |
| desc_type | input | 3 | Encoded type of the target descriptor |
| desc_dpl | input | 2 | Target descriptor privilege level |
| desc_present | input | 1 | Target descriptor present bit |
| desc_busy | input | 1 | Target TSS busy bit |
| cpl | input | 2 | Current privilege level |
| inner_sel | input | SEL_W | Selector held inside a gate |
| inner_type | input | 3 | Encoded type of the descriptor the inner selector points at |
| inner_dpl | input | 2 | Inner descriptor privilege level |
| inner_present | input | 1 | Inner descriptor present bit |
| inner_busy | input | 1 | Inner TSS busy bit |
| res_valid | output | 1 | Result strobe |
| res_kind | output | 3 | 0 conforming, 1 nonconforming, 2 gate same, 3 gate more, 4 task, 5 fault |
| fault_cls | output | 2 | 0 GP, 1 NP, 2 SS, 3 TS |
| fault_code | output | SEL_W | Error-code selector |

## Verification
For every descriptor type, the bench sweeps all combinations of descriptor DPL, CPL, RPL, present bit and busy bit. This separates the three privilege rules (DPL no higher than CPL, DPL equal to CPL, DPL at least both CPL and RPL) and shows that privilege faults outrank not-present faults. A second sweep fixes a legal gate and walks CPL and every field of the inner descriptor, with the inner table bit set and clear. This separates the same-privilege and more-privilege call-gate paths from the inner-selector faults, and the GP class used by call gates from the TS class used by task gates. Index sweeps across both table limits, with the null selector included, check the boundary at limit and limit+1 and that the table bit picks the limit.

// File: rtl/farcall_gatekeeper.sv
module farcall_gatekeeper #(
  parameter int SEL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [SEL_W-1:0] tgt_sel,
  input  logic [SEL_W-4:0] gdt_lim,
  input  logic [SEL_W-4:0] ldt_lim,
  input  logic [2:0]       desc_type,
  input  logic [1:0]       desc_dpl,
  input  logic             desc_present,
  input  logic             desc_busy,
  input  logic [1:0]       cpl,
  input  logic [SEL_W-1:0] inner_sel,
  input  logic [2:0]       inner_type,
  input  logic [1:0]       inner_dpl,
  input  logic             inner_present,
  input  logic             inner_busy,
  output logic             res_valid,
  output logic [2:0]       res_kind,
  output logic [1:0]       fault_cls,
  output logic [SEL_W-1:0] fault_code
);
  localparam int IW = SEL_W - 3;
  localparam logic [SEL_W-1:0] LOW_MASK = {{(SEL_W-2){1'b1}}, 2'b00};

  localparam logic [2:0] T_CONF = 3'd1, T_NONC = 3'd2, T_CGATE = 3'd3,
                         T_TGATE = 3'd4, T_TSS = 3'd5;
  localparam logic [2:0] K_CONF = 3'd0, K_NONC = 3'd1, K_SAME = 3'd2,
                         K_MORE = 3'd3, K_TASK = 3'd4, K_FAULT = 3'd5;
  localparam logic [1:0] C_GP = 2'd0, C_NP = 2'd1, C_TS = 2'd3;

  wire [1:0]       rpl     = tgt_sel[1:0];
  wire [IW-1:0]    t_idx   = tgt_sel[SEL_W-1:3];
  wire [IW-1:0]    i_idx   = inner_sel[SEL_W-1:3];
  wire [SEL_W-1:0] t_err   = tgt_sel & LOW_MASK;
  wire [SEL_W-1:0] i_err   = inner_sel & LOW_MASK;

  wire t_null  = tgt_sel[SEL_W-1:2] == '0;
  wire t_oob   = t_idx > (tgt_sel[2] ? ldt_lim : gdt_lim);
  wire i_null  = inner_sel[SEL_W-1:2] == '0;
  wire i_oob   = i_idx > (inner_sel[2] ? ldt_lim : gdt_lim);
  wire i_oob_g = i_idx > gdt_lim;

  wire gate_ok    = (desc_dpl >= cpl) && (desc_dpl >= rpl);
  wire inner_code = (inner_type == T_CONF) || (inner_type == T_NONC);
  wire go_more    = (inner_type == T_NONC) && (inner_dpl < cpl);

  logic [2:0]       nx_kind;
  logic [1:0]       nx_cls;
  logic [SEL_W-1:0] nx_code;

  always_comb begin
    nx_kind = K_FAULT;
    nx_cls  = C_GP;
    nx_code = '0;
    if (t_null) begin
      nx_code = '0;
    end else if (t_oob) begin
      nx_code = t_err;
    end else begin
      unique case (desc_type)
        T_CONF: begin
          if (desc_dpl > cpl)     nx_code = t_err;
          else if (!desc_present) begin nx_cls = C_NP; nx_code = t_err; end
          else                    nx_kind = K_CONF;
        end
        T_NONC: begin
          if (rpl > cpl)              nx_code = t_err;
          else if (desc_dpl != cpl)   nx_code = t_err;
          else if (!desc_present)     begin nx_cls = C_NP; nx_code = t_err; end
          else                        nx_kind = K_NONC;
        end
        T_CGATE: begin
          if (!gate_ok)               nx_code = t_err;
          else if (!desc_present)     begin nx_cls = C_NP; nx_code = t_err; end
          else if (i_null)            nx_code = '0;
          else if (i_oob)             nx_code = i_err;
          else if (!inner_code)       nx_code = i_err;
          else if (inner_dpl > cpl)   nx_code = i_err;
          else                        nx_kind = go_more ? K_MORE : K_SAME;
        end
        T_TGATE: begin
          if (!gate_ok)               begin nx_cls = C_TS; nx_code = t_err; end
          else if (!desc_present)     begin nx_cls = C_NP; nx_code = t_err; end
          else if (inner_sel[2] || i_oob_g || inner_type != T_TSS || inner_busy)
                                      begin nx_cls = C_TS; nx_code = i_err; end
          else if (!inner_present)    begin nx_cls = C_NP; nx_code = i_err; end
          else                        nx_kind = K_TASK;
        end
        T_TSS: begin
          if (!gate_ok || desc_busy)  begin nx_cls = C_TS; nx_code = t_err; end
          else if (!desc_present)     begin nx_cls = C_NP; nx_code = t_err; end
          else                        nx_kind = K_TASK;
        end
        default: nx_code = t_err;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_kind   <= '0;
      fault_cls  <= '0;
      fault_code <= '0;
    end else begin
      res_valid <= req_valid;
      if (req_valid) begin
        res_kind   <= nx_kind;
        fault_cls  <= nx_cls;
        fault_code <= nx_code;
      end
    end
  end
endmodule

// File: rtl/farcall_gatekeeper_chk.sv
module farcall_gatekeeper_chk #(
  parameter int SEL_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [SEL_W-1:0] tgt_sel,
  input logic [1:0]       cpl,
  input logic [1:0]       inner_dpl,
  input logic             res_valid,
  input logic [2:0]       res_kind,
  input logic [1:0]       fault_cls,
  input logic [SEL_W-1:0] fault_code
);
  localparam logic [2:0] K_NONC = 3'd1, K_MORE = 3'd3, K_FAULT = 3'd5;

  a_r10_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid == $past(req_valid));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(res_kind) && $stable(fault_cls) && $stable(fault_code));

  a_r10_clean_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_kind != K_FAULT) |-> (fault_cls == 2'd0 && fault_code == '0));

  a_r10_kind_range: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_kind <= K_FAULT);

  a_r1_null: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && tgt_sel[SEL_W-1:2] == '0) |=>
      (res_kind == K_FAULT && fault_cls == 2'd0 && fault_code == '0));

  a_r4_rpl: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && tgt_sel[1:0] > cpl) |=> res_kind != K_NONC);

  a_r6_more: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && inner_dpl >= cpl) |=> res_kind != K_MORE);
endmodule

bind farcall_gatekeeper farcall_gatekeeper_chk #(.SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .tgt_sel(tgt_sel),
  .cpl(cpl), .inner_dpl(inner_dpl), .res_valid(res_valid),
  .res_kind(res_kind), .fault_cls(fault_cls), .fault_code(fault_code));

// File: tb/test_farcall_gatekeeper.sv
module test_farcall_gatekeeper;
  logic clk = 0, rst_n = 0, req = 0;
  logic [15:0] ts = 0, is = 0;
  logic [12:0] gl = 13'd20, ll = 13'd30;
  logic [2:0] ty = 0, ity = 0;
  logic [1:0] dp = 0, cp = 0, idp = 0;
  logic pr = 0, bu = 0, ipr = 0, ibu = 0;
  logic rv;
  logic [2:0] rk;
  logic [1:0] rc;
  logic [15:0] rcode;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  farcall_gatekeeper i_farcall_gatekeeper (
    .clk(clk), .rst_n(rst_n), .req_valid(req), .tgt_sel(ts),
    .gdt_lim(gl), .ldt_lim(ll), .desc_type(ty), .desc_dpl(dp),
    .desc_present(pr), .desc_busy(bu), .cpl(cp), .inner_sel(is),
    .inner_type(ity), .inner_dpl(idp), .inner_present(ipr),
    .inner_busy(ibu), .res_valid(rv), .res_kind(rk), .fault_cls(rc),
    .fault_code(rcode));

  function automatic logic [20:0] fault(input logic [1:0] c, input logic [15:0] code);
    return {3'd5, c, code};
  endfunction

  function automatic logic [20:0] model();
    logic [15:0] te = {ts[15:2], 2'b00};
    logic [15:0] ie = {is[15:2], 2'b00};
    logic [1:0]  r  = ts[1:0];
    if (ts[15:2] == 0) return fault(0, 0);
    if (ts[15:3] > (ts[2] ? ll : gl)) return fault(0, te);
    case (ty)
      3'd1: begin
        if (dp > cp) return fault(0, te);
        if (!pr) return fault(1, te);
        return {3'd0, 18'd0};
      end
      3'd2: begin
        if (r > cp || dp != cp) return fault(0, te);
        if (!pr) return fault(1, te);
        return {3'd1, 18'd0};
      end
      3'd3: begin
        if (dp < cp || dp < r) return fault(0, te);
        if (!pr) return fault(1, te);
        if (is[15:2] == 0) return fault(0, 0);
        if (is[15:3] > (is[2] ? ll : gl)) return fault(0, ie);
        if (ity != 3'd1 && ity != 3'd2) return fault(0, ie);
        if (idp > cp) return fault(0, ie);
        if (ity == 3'd2 && idp < cp) return {3'd3, 18'd0};
        return {3'd2, 18'd0};
      end
      3'd4: begin
        if (dp < cp || dp < r) return fault(3, te);
        if (!pr) return fault(1, te);
        if (is[2] || is[15:3] > gl || ity != 3'd5 || ibu) return fault(3, ie);
        if (!ipr) return fault(1, ie);
        return {3'd4, 18'd0};
      end
      3'd5: begin
        if (dp < cp || dp < r || bu) return fault(3, te);
        if (!pr) return fault(1, te);
        return {3'd4, 18'd0};
      end
      default: return fault(0, te);
    endcase
  endfunction

  task automatic check(input string tag, input logic [20:0] exp, input logic evalid);
    n_run++;
    if (rv !== evalid || {rk, rc, rcode} !== exp) begin
      n_fail++;
      $display("FAIL %s: got v=%0b k=%0d c=%0d code=%h, expected v=%0b k=%0d c=%0d code=%h",
               tag, rv, rk, rc, rcode, evalid, exp[20:18], exp[17:16], exp[15:0]);
    end
  endtask

  task automatic run_one(input string tag);
    logic [20:0] e;
    e = model();
    req = 1;
    @(negedge clk);
    check(tag, e, 1'b1);
  endtask

  function automatic string type_tag(input logic [2:0] t);
    case (t)
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R7";
      3'd5: return "R8";
      default: return "R9";
    endcase
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got no completion, expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [20:0] last;
    repeat (3) @(negedge clk);
    check("R10 reset", 21'd0, 1'b0);
    rst_n = 1;
    @(negedge clk);

    // Primary sweep: every type and privilege/present/busy combination (R3 R4 R5 R7 R8 R9)
    is = {13'd7, 1'b0, 2'd0}; ity = 3'd2; idp = 0; ipr = 1; ibu = 0;
    for (int t = 0; t < 8; t++)
      for (int d = 0; d < 4; d++)
        for (int c = 0; c < 4; c++)
          for (int r = 0; r < 4; r++)
            for (int p = 0; p < 2; p++)
              for (int b = 0; b < 2; b++) begin
                ty = t[2:0]; dp = d[1:0]; cp = c[1:0];
                pr = p[0]; bu = b[0];
                ts = {13'd5, 1'b0, r[1:0]};
                run_one(type_tag(ty));
              end

    // Gate sweep: legal gate, every inner descriptor combination (R6 R7)
    ts = {13'd5, 1'b0, 2'd0}; dp = 3; pr = 1; bu = 0;
    for (int g = 3; g < 5; g++)
      for (int c = 0; c < 4; c++)
        for (int t = 0; t < 8; t++)
          for (int d = 0; d < 4; d++)
            for (int p = 0; p < 2; p++)
              for (int b = 0; b < 2; b++)
                for (int ti = 0; ti < 2; ti++) begin
                  ty = g[2:0]; cp = c[1:0]; ity = t[2:0]; idp = d[1:0];
                  ipr = p[0]; ibu = b[0];
                  is = {13'd9, ti[0], 2'd1};
                  run_one(g == 3 ? "R6" : "R7");
                end

    // Index sweep across table limits, both tables, target selector (R1 R2)
    ty = 3'd2; dp = 0; cp = 0; pr = 1;
    for (int ti = 0; ti < 2; ti++)
      for (int x = 0; x < 40; x++)
        for (int r = 0; r < 2; r++) begin
          ts = {x[12:0], ti[0], r[1:0]};
          run_one((x == 0 && ti == 0) ? "R1" : "R2");
        end

    // Inner selector index sweep for call gates and task gates (R6 R7)
    ts = {13'd5, 1'b0, 2'd0}; dp = 3; cp = 1; ipr = 1; ibu = 0;
    for (int g = 3; g < 5; g++)
      for (int ti = 0; ti < 2; ti++)
        for (int x = 0; x < 40; x++) begin
          ty = g[2:0]; ity = (g == 3) ? 3'd2 : 3'd5; idp = 0;
          is = {x[12:0], ti[0], 2'd2};
          run_one(g == 3 ? "R6" : "R7");
        end

    // Hold: no request leaves results unchanged and strobe low (R10)
    last = {rk, rc, rcode};
    req = 0; ty = 3'd0; ts = 16'hFFFF;
    @(negedge clk);
    check("R10 hold", last, 1'b0);
    @(negedge clk);
    check("R10 hold2", last, 1'b0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule